// File: doc/BRIEF.md
# Guarded Byte-Wide Nonvolatile Data Memory Controller

This block sits between a simple single-cycle register bus and a 256-byte data memory array. Software reaches the array through four bus registers: an address register, a data register, a control register and a key register. The key register has no storage. A read is a single bus write that sets a read strobe. The addressed byte is then in the data register on the next bus cycle.

Writing a byte is deliberately awkward. The write-enable bit must already be set. Software must then write 55h and AAh to the key register on back-to-back bus accesses. The very next bus access must be a control write that sets the write-start bit. The programming delay is modelled by a counter of `WRITE_CYCLES` clocks. During that delay the address, data and control registers ignore the bus. At the end, hardware commits the byte, drops the start bit and raises a sticky completion flag. That flag, gated by an interrupt-enable bit, drives the interrupt output.

For `HOLDOFF_CYCLES` clocks after any reset, no write can start. A warm reset taken during a write leaves an error bit standing. Only a power-on reset, or software writing 0 to that bit, clears it.

Top module: `guarded_nvm_ctrl`

## Requirements
- R1: After reset, the address, data, control and key registers all read 00h. The bus register select is 0 = address, 1 = data, 2 = control, 3 = key. The key register reads 00h at all times. Control bits 7:6 always read 0.
- R2: A control write (select 2) with bit 0 (read strobe) set loads the data register with the array byte at the current address. The data register shows that byte on the next bus cycle. Bit 0 always reads back as 0.
- R3: The data register keeps its value until the next read strobe or a bus write to it. Changing the address register does not alter it.
- R4: A write starts only when three bus accesses occur back to back: 55h written to the key register, then AAh written to the key register, then a control write with bit 1 (write start) set. Any other access between these steps cancels the arming. Every byte needs a fresh sequence.
- R5: A write cannot start unless control bit 2 (write enable) was already 1 before the control write that sets bit 1.
- R6: Once a write starts, control bit 1 reads 1 for exactly `WRITE_CYCLES` clocks and then clears. Bus writes to the address, data and control registers are ignored while bit 1 is 1. This includes a write that lands in the final cycle of the write.
- R7: A completed write sets control bit 4 (done). Bit 4 clears only when software writes 0 to it; writing 1 has no effect. The output `irq` equals bit 4 AND control bit 5 (interrupt enable).
- R8: Hardware never clears the write-enable bit (bit 2). Only a reset or a bus write clears it.
- R9: No write can start during the first `HOLDOFF_CYCLES` clocks after reset, even when the key sequence is correct.
- R10: If `rstN` is asserted while a write is in progress, control bit 3 (write error) is set afterwards. It survives `rstN`. It is cleared by `porN`, or by a control write with bit 3 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, synchronous, active low; clears everything including the error bit |
| rstN | input | 1 | Warm reset, synchronous, active low; records an interrupted write |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write access, 0 = read access |
| busAddr | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the selected register (combinational) |
| irq | output | 1 | Completion interrupt (done AND interrupt enable) |

## Verification
Two functions can meet in one cycle: a write completing, and a software write to the control register. The bench provokes this by placing a control write, which tries to clear write-enable, on the exact clock where the write counter expires. The result is judged correct when control then reads 14h: write-enable is kept and done is set. The second meeting is a warm reset landing mid-write. It is judged by the error bit reading 1 once reset is released. The same bit must read 0 after a power-on reset.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int DATA_W = 8;

  localparam logic [1:0] REG_ADDR = 2'd0;
  localparam logic [1:0] REG_DATA = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_KEY  = 2'd3;

  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_EN   = 2;
  localparam int CB_ERR  = 3;
  localparam int CB_DONE = 4;
  localparam int CB_IE   = 5;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_ARMED} unlock_e;

  typedef struct packed {
    logic ldAddr;
    logic ldData;
    logic doRead;
    logic doCommit;
  } dpStrobe_t;
endpackage

// File: rtl/nvm_ctrl_fsm.sv
module nvm_ctrl_fsm
  import nvm_pkg::*;
#(
  parameter int WRITE_CYCLES   = 8,
  parameter int HOLDOFF_CYCLES = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] ctrlByte
);
  localparam int WC_W = $clog2(WRITE_CYCLES + 1);
  localparam int HO_W = $clog2(HOLDOFF_CYCLES + 1);

  unlock_e         ulState, ulNext;
  logic            busy, wrEn, wrErr, done, irqEn;
  logic [WC_W-1:0] wcLeft;
  logic [HO_W-1:0] hoLeft;
  logic            sysRst, wrAcc, ctrlWr, startOk, commit;

  assign sysRst  = !porN || !rstN;
  assign wrAcc   = busSel && busWr;
  assign ctrlWr  = wrAcc && (busAddr == REG_CTRL) && !busy;
  assign startOk = (ulState == UL_ARMED) && ctrlWr && busWdata[CB_WR]
                   && wrEn && (hoLeft == '0);
  assign commit  = busy && (wcLeft == WC_W'(1));

  // Key sequencer: any bus access that is not the expected next step drops to idle
  always_comb begin
    ulNext = ulState;
    if (busSel) begin
      ulNext = UL_IDLE;
      if (wrAcc && busAddr == REG_KEY) begin
        if (ulState == UL_IDLE && busWdata == KEY_FIRST)       ulNext = UL_HALF;
        else if (ulState == UL_HALF && busWdata == KEY_SECOND) ulNext = UL_ARMED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sysRst) begin
      ulState <= UL_IDLE;
      busy    <= 1'b0;
      wcLeft  <= '0;
      hoLeft  <= HO_W'(HOLDOFF_CYCLES);
      wrEn    <= 1'b0;
      done    <= 1'b0;
      irqEn   <= 1'b0;
    end else begin
      ulState <= ulNext;
      if (hoLeft != '0) hoLeft <= hoLeft - HO_W'(1);
      if (startOk) begin
        busy   <= 1'b1;
        wcLeft <= WC_W'(WRITE_CYCLES);
      end else if (busy) begin
        wcLeft <= wcLeft - WC_W'(1);
        if (commit) busy <= 1'b0;
      end
      if (ctrlWr) begin
        wrEn  <= busWdata[CB_EN];
        irqEn <= busWdata[CB_IE];
      end
      if (commit)      done <= 1'b1;
      else if (ctrlWr) done <= done & busWdata[CB_DONE];
    end
  end

  // Error bit lives across the warm reset
  always_ff @(posedge clk) begin
    if (!porN)       wrErr <= 1'b0;
    else if (!rstN)  wrErr <= wrErr | busy;
    else if (ctrlWr) wrErr <= wrErr & busWdata[CB_ERR];
  end

  always_comb begin
    strobe.ldAddr   = wrAcc && busAddr == REG_ADDR && !busy;
    strobe.ldData   = wrAcc && busAddr == REG_DATA && !busy;
    strobe.doRead   = ctrlWr && busWdata[CB_RD];
    strobe.doCommit = commit;
  end

  assign ctrlByte = {2'b00, irqEn, done, wrErr, wrEn, busy, 1'b0};
endmodule

// File: rtl/nvm_datapath.sv
module nvm_datapath
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] ctrlByte,
  output logic [DATA_W-1:0] busRdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (clr) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.ldAddr) addrReg <= busWdata[ADDR_W-1:0];
      if (strobe.doRead)      dataReg <= cells[addrReg];
      else if (strobe.ldData) dataReg <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.doCommit) cells[addrReg] <= dataReg;
  end

  always_comb begin
    unique case (busAddr)
      REG_ADDR: busRdata = DATA_W'(addrReg);
      REG_DATA: busRdata = dataReg;
      REG_CTRL: busRdata = ctrlByte;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/guarded_nvm_ctrl.sv
module guarded_nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int WRITE_CYCLES   = 8,
  parameter int HOLDOFF_CYCLES = 16
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irq
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] ctrlByte;

  nvm_ctrl_fsm #(
    .WRITE_CYCLES  (WRITE_CYCLES),
    .HOLDOFF_CYCLES(HOLDOFF_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .porN    (porN),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .strobe  (strobe),
    .ctrlByte(ctrlByte)
  );

  nvm_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .clr     (!porN || !rstN),
    .strobe  (strobe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .ctrlByte(ctrlByte),
    .busRdata(busRdata)
  );

  assign irq = ctrlByte[CB_DONE] & ctrlByte[CB_IE];
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
  parameter int HOLDOFF_CYCLES = 16
) (
  input logic       clk,
  input logic       porN,
  input logic       rstN,
  input logic       busSel,
  input logic       busWr,
  input logic [1:0] busAddr,
  input logic [7:0] busWdata,
  input logic [7:0] ctrlByte,
  input logic       irq
);
  logic        inRst, ctrlWrite;
  logic [31:0] sinceRst;

  assign inRst     = !porN || !rstN;
  assign ctrlWrite = busSel && busWr && (busAddr == 2'd2);

  always_ff @(posedge clk) begin
    if (inRst)                  sinceRst <= '0;
    else if (sinceRst != '1)    sinceRst <= sinceRst + 32'd1;
  end

  // R4
  start_needs_ctrl_write_chk: assert property (@(posedge clk) disable iff (inRst)
    $rose(ctrlByte[1]) |-> $past(ctrlWrite && busWdata[1]));

  // R5
  start_needs_prior_enable_chk: assert property (@(posedge clk) disable iff (inRst)
    $rose(ctrlByte[1]) |-> $past(ctrlByte[2]));

  // R6
  finish_sets_done_chk: assert property (@(posedge clk) disable iff (inRst)
    $fell(ctrlByte[1]) |-> ctrlByte[4]);

  // R7
  done_clear_by_bus_chk: assert property (@(posedge clk) disable iff (inRst)
    $fell(ctrlByte[4]) |-> $past(ctrlWrite && !busWdata[4]));

  // R7
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (inRst)
    irq |-> ctrlByte[4] && ctrlByte[5]);

  // R8
  enable_clear_by_bus_chk: assert property (@(posedge clk) disable iff (inRst)
    $fell(ctrlByte[2]) |-> $past(ctrlWrite && !ctrlByte[1]));

  // R9
  holdoff_window_chk: assert property (@(posedge clk) disable iff (inRst)
    $rose(ctrlByte[1]) |-> sinceRst > HOLDOFF_CYCLES);

  // R1
  always_comb begin
    upper_bits_zero_chk: assert (inRst || ctrlByte[7:6] == 2'b00);
  end
endmodule

bind guarded_nvm_ctrl nvm_ctrl_chk #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_chk (
  .clk     (clk),
  .porN    (porN),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .ctrlByte(ctrlByte),
  .irq     (irq)
);

// File: tb/tb_guarded_nvm_ctrl.sv
`timescale 1ns/1ps
module tb_guarded_nvm_ctrl;
  localparam int WC = 8;
  localparam int HO = 16;
  localparam logic [1:0] A_ADDR = 2'd0, A_DATA = 2'd1, A_CTRL = 2'd2, A_KEY = 2'd3;

  logic       clk = 1'b0;
  logic       porN, rstN, busSel, busWr;
  logic [1:0] busAddr;
  logic [7:0] busWdata, busRdata, rdVal;
  logic       irq;
  int         checks = 0, errors = 0;

  always #2 clk = ~clk;

  guarded_nvm_ctrl #(.ADDR_W(8), .WRITE_CYCLES(WC), .HOLDOFF_CYCLES(HO)) dut (
    .clk(clk), .porN(porN), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq));

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255) ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a; busWdata = 8'h00;
    #1 rdVal = busRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busSel = 1'b0; busWr = 1'b0;
    end
  endtask

  task automatic unlockStart(input logic [7:0] ctl);
    wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); wr(A_CTRL, ctl);
  endtask

  // Full write; returns number of polls that saw the start bit high
  task automatic byteWrite(input logic [7:0] a, input logic [7:0] d, output int hi);
    wr(A_ADDR, a); wr(A_DATA, d); unlockStart(8'h06);
    hi = 0;
    for (int k = 0; k < 4 * WC + 8; k++) begin
      rd(A_CTRL);
      if (rdVal[1]) hi++;
      else break;
    end
  endtask

  task automatic finishRun;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int hi;
    porN = 1'b0; rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = 2'd0; busWdata = 8'h00;
    idle(3);
    porN = 1'b1; rstN = 1'b1;

    // R1 reset values and key read-back
    rd(A_ADDR); check("R1 addr", rdVal, 8'h00);
    rd(A_DATA); check("R1 data", rdVal, 8'h00);
    rd(A_CTRL); check("R1 ctrl", rdVal, 8'h00);
    rd(A_KEY);  check("R1 key", rdVal, 8'h00);

    // R9 correct sequence inside hold-off does not start
    wr(A_CTRL, 8'h04); unlockStart(8'h06);
    rd(A_CTRL); check("R9 holdoff blocks", rdVal, 8'h04);
    idle(HO + 4);

    // R5 enable and start in one write
    wr(A_CTRL, 8'h00); unlockStart(8'h06);
    rd(A_CTRL); check("R5 same-write enable", rdVal, 8'h04);

    // R6 sweep: every address, timing and completion
    for (int a = 0; a < 256; a++) begin
      byteWrite(8'(a), pat(a), hi);
      check("R6 busy length", 8'(hi), 8'(WC));
      check("R6 R7 R8 done ctrl", rdVal, 8'h14);
      wr(A_CTRL, 8'h04);
    end

    // R2 read-back sweep
    for (int a = 0; a < 256; a++) begin
      wr(A_ADDR, 8'(a)); wr(A_CTRL, 8'h05);
      rd(A_DATA); check("R2 readback", rdVal, pat(a));
    end
    rd(A_CTRL); check("R2 strobe reads 0", rdVal, 8'h04);
    rd(A_KEY);  check("R1 key after use", rdVal, 8'h00);

    // R3 data register retention
    wr(A_ADDR, 8'h03);
    rd(A_DATA); check("R3 kept over addr change", rdVal, pat(255));
    wr(A_DATA, 8'h3C);
    rd(A_DATA); check("R3 bus write", rdVal, 8'h3C);
    wr(A_CTRL, 8'h05);
    rd(A_DATA); check("R3 new read", rdVal, pat(3));

    // R4 broken sequences
    wr(A_ADDR, 8'h10); wr(A_DATA, 8'hEE);
    wr(A_KEY, 8'h55); rd(A_ADDR); wr(A_KEY, 8'hAA); wr(A_CTRL, 8'h06);
    rd(A_CTRL); check("R4 access between keys", rdVal, 8'h04);
    wr(A_KEY, 8'hAA); wr(A_KEY, 8'h55); wr(A_CTRL, 8'h06);
    rd(A_CTRL); check("R4 keys swapped", rdVal, 8'h04);
    wr(A_KEY, 8'h55); wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); wr(A_CTRL, 8'h06);
    rd(A_CTRL); check("R4 doubled first key", rdVal, 8'h04);
    wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); rd(A_CTRL); wr(A_CTRL, 8'h06);
    rd(A_CTRL); check("R4 access before start", rdVal, 8'h04);
    wr(A_CTRL, 8'h05);
    rd(A_DATA); check("R4 cell untouched", rdVal, pat(16));
    byteWrite(8'h10, pat(16), hi);
    wr(A_CTRL, 8'h04);
    wr(A_CTRL, 8'h06);
    rd(A_CTRL); check("R4 no reuse of key", rdVal, 8'h04);

    // R6 lockout, including a control write on the completion edge
    wr(A_ADDR, 8'h20); wr(A_DATA, 8'h99); unlockStart(8'h06);
    wr(A_ADDR, 8'h30); wr(A_DATA, 8'h11); wr(A_CTRL, 8'h00);
    idle(WC - 4);
    wr(A_CTRL, 8'h00);
    rd(A_CTRL); check("R6 R8 ctrl locked at finish", rdVal, 8'h14);
    rd(A_ADDR); check("R6 addr locked", rdVal, 8'h20);
    rd(A_DATA); check("R6 data locked", rdVal, 8'h99);
    wr(A_CTRL, 8'h04); wr(A_DATA, 8'h00); wr(A_CTRL, 8'h05);
    rd(A_DATA); check("R6 committed byte", rdVal, 8'h99);

    // R7 done flag and interrupt gating
    byteWrite(8'h21, 8'h42, hi);
    #1 check("R7 irq off when disabled", 8'(irq), 8'h00);
    wr(A_CTRL, 8'h34);
    rd(A_CTRL); check("R7 done kept by write of 1", rdVal, 8'h34);
    #1 check("R7 irq on", 8'(irq), 8'h01);
    wr(A_CTRL, 8'h24);
    rd(A_CTRL); check("R7 done cleared", rdVal, 8'h24);
    #1 check("R7 irq off", 8'(irq), 8'h00);
    wr(A_CTRL, 8'h34);
    rd(A_CTRL); check("R7 write 1 cannot set", rdVal, 8'h24);
    idle(40);
    rd(A_CTRL); check("R8 enable persists", rdVal, 8'h24);

    // R10 warm reset during a write
    wr(A_ADDR, 8'h40); wr(A_DATA, 8'h77); unlockStart(8'h06);
    idle(2);
    rstN = 1'b0; idle(2); rstN = 1'b1;
    rd(A_CTRL); check("R10 error after warm reset", rdVal, 8'h08);
    wr(A_CTRL, 8'h08);
    rd(A_CTRL); check("R10 write 1 keeps error", rdVal, 8'h08);
    wr(A_CTRL, 8'h00);
    rd(A_CTRL); check("R10 write 0 clears", rdVal, 8'h00);
    idle(HO + 2);
    wr(A_CTRL, 8'h04); wr(A_ADDR, 8'h41); unlockStart(8'h06);
    idle(2);
    rstN = 1'b0; idle(2); rstN = 1'b1;
    rd(A_CTRL); check("R10 error set again", rdVal, 8'h08);
    porN = 1'b0; idle(2); porN = 1'b1;
    rd(A_CTRL); check("R10 power-on clears", rdVal, 8'h00);

    idle(2);
    finishRun();
  end
endmodule